// File: doc/BRIEF.md
# Per-Cycle Active Power Accumulator

This block takes DC-free current and voltage samples for three line phases and produces average active power per line cycle and per ten-cycle period. Samples arrive one per clock when `smp_vld` is high, with a phase index on `smp_ph`. The phases come interleaved: 0, 1, 2, 0, 1, 2 and so on. Each accepted sample is multiplied (current times voltage of the same phase) and summed into that phase's cycle sum. A line cycle ends with the 64th accepted sample of phase 2. The sum is then divided by 64 using an arithmetic shift, which gives the cycle power. The block presents the cycle power of every phase and their total for one clock.

Every cycle power is steered by sign. A non-negative value adds to the phase's import energy and a negative value adds its magnitude to the phase's export energy. Both energy registers are unsigned and saturate at full scale. After every ten cycles the block publishes a snapshot with a one-clock valid pulse. The snapshot holds the per-phase sums of cycle power over the period, their total, the import and export energies and the number of periods since reset. The snapshot stays constant until the next period ends.

Top module: `apa_power_acc`

## Requirements
- R1: While reset is asserted and after it, before any cycle completes, all result outputs are zero and `cyc_vld` and `res_vld` are low.
- R2: For each phase, `cyc_pwr` equals the sum of the 64 current-times-voltage products of the cycle, shifted right arithmetically by 6 (that is, rounded toward minus infinity). Phase k occupies bits [k*32 +: 32], two's complement. It is valid in the one clock after the edge that captures the 64th phase-2 sample, and `cyc_vld` is high for exactly that clock.
- R3: Full-scale operands do not overflow: 64 products of -32768 times -32768 give a cycle power of exactly 2^30.
- R4: `cyc_tot` equals the signed sum of the three phase cycle powers.
- R5: A sample with `smp_vld` low, or with a phase index of 3, changes no cycle sum and no sample count.
- R6: A cycle power of zero or above adds to that phase's import energy (`res_imp`, phase k at [k*ACC_W +: ACC_W]). A negative cycle power adds its magnitude to that phase's export energy (`res_exp`).
- R7: The energy registers saturate at 2^ACC_W-1 rather than wrapping.
- R8: `res_vld` pulses for one clock, one clock after the `cyc_vld` of every tenth cycle. The snapshot outputs do not change while `res_vld` is low.
- R9: `res_win` holds, per phase, the signed sum of that period's ten cycle powers (phase k at [k*37 +: 37]). `res_tot` holds the sum of the three.
- R10: `res_periods` counts the ten-cycle periods completed since reset and increments by one at each snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_vld | input | 1 | Sample present this clock |
| smp_ph | input | 2 | Phase index of the sample (0..2 valid) |
| smp_i | input | SMP_W | Current sample, two's complement |
| smp_u | input | SMP_W | Voltage sample, two's complement |
| cyc_vld | output | 1 | Cycle power outputs valid (one clock) |
| cyc_pwr | output | PHASES*2*SMP_W | Per-phase cycle power |
| cyc_tot | output | 2*SMP_W+2 | Sum of phase cycle powers |
| res_vld | output | 1 | Period snapshot just updated (one clock) |
| res_win | output | PHASES*WIN_W | Per-phase sum of cycle powers over the period |
| res_tot | output | WIN_W+2 | Sum of the per-phase period sums |
| res_imp | output | PHASES*ACC_W | Per-phase import energy, saturating |
| res_exp | output | PHASES*ACC_W | Per-phase export energy, saturating |
| res_periods | output | CNT_W | Periods completed since reset |

## Verification
The hardest state to reach is energy saturation. With 48-bit registers it would take hundreds of thousands of full-scale cycles. The bench therefore runs a second instance with 32-bit energy registers on the same stimulus. A period of full-scale positive power on one phase and full-scale negative power on another drives both its import and export registers to the limit, while the 48-bit instance still shows the exact sums. Floor rounding is exposed by cycles whose only nonzero product is -1 or whose products sum to 63. Invalid-phase and invalid-strobe samples carrying full-scale data are interleaved with every group, so any leak shows in the cycle powers.

// File: rtl/apa_pkg.sv
`timescale 1ns/1ps
package apa_pkg;
  localparam int unsigned PH_W = 2;
  typedef logic [PH_W-1:0] ph_t;
endpackage

// File: rtl/apa_sample_ctr.sv
`timescale 1ns/1ps
module apa_sample_ctr
  import apa_pkg::*;
#(
  parameter int unsigned PHASES     = 3,
  parameter int unsigned CYC_LEN    = 64,
  parameter int unsigned PERIOD_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_vld,
  input  ph_t  smp_ph,
  output logic cycle_end,
  output logic period_end
);
  localparam int unsigned CYC_W = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
  localparam int unsigned PER_W = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;

  logic [CYC_W-1:0] grp_q, grp_nx;
  logic [PER_W-1:0] per_q, per_nx;
  logic             last_ph;

  assign last_ph    = smp_vld && (smp_ph == ph_t'(PHASES - 1));
  assign cycle_end  = last_ph && (grp_q == CYC_W'(CYC_LEN - 1));
  assign period_end = cycle_end && (per_q == PER_W'(PERIOD_CYC - 1));

  always_comb begin
    grp_nx = grp_q;
    per_nx = per_q;
    if (last_ph) begin
      grp_nx = cycle_end ? '0 : grp_q + 1'b1;
    end
    if (cycle_end) begin
      per_nx = period_end ? '0 : per_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q <= '0;
      per_q <= '0;
    end else begin
      grp_q <= grp_nx;
      per_q <= per_nx;
    end
  end

  // R5: the group count restarts after a completed cycle
  a_r5_group_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |=> (grp_q == '0));

  // R8: the period count restarts after a period ends
  a_r8_period_restart: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (per_q == '0));
endmodule

// File: rtl/apa_phase_mac.sv
`timescale 1ns/1ps
module apa_phase_mac
  import apa_pkg::*;
#(
  parameter int unsigned SMP_W   = 16,
  parameter int unsigned CYC_LEN = 64,
  parameter int unsigned PH_IDX  = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  ph_t                  smp_ph,
  input  logic [SMP_W-1:0]     smp_i,
  input  logic [SMP_W-1:0]     smp_u,
  input  logic                 cycle_end,
  output logic [2*SMP_W-1:0]   cyc_pwr
);
  localparam int unsigned POW_W    = 2 * SMP_W;
  localparam int unsigned CYC_LOG2 = $clog2(CYC_LEN);
  localparam int unsigned SUM_W    = POW_W + CYC_LOG2;

  logic signed [SMP_W-1:0] s_i, s_u;
  logic signed [POW_W-1:0] prod;
  logic signed [SUM_W-1:0] prod_ext, sum_in, sum_q, sum_nx, scaled;
  logic        [POW_W-1:0] pwr_q, pwr_nx;
  logic                    take;

  assign s_i      = smp_i;
  assign s_u      = smp_u;
  assign take     = smp_vld && (smp_ph == ph_t'(PH_IDX));
  assign prod     = s_i * s_u;
  assign prod_ext = take ? SUM_W'(prod) : '0;
  assign sum_in   = sum_q + prod_ext;
  assign scaled   = sum_in >>> CYC_LOG2;

  always_comb begin
    sum_nx = sum_in;
    pwr_nx = pwr_q;
    if (cycle_end) begin
      sum_nx = '0;
      pwr_nx = POW_W'(scaled);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      pwr_q <= '0;
    end else begin
      sum_q <= sum_nx;
      pwr_q <= pwr_nx;
    end
  end

  assign cyc_pwr = pwr_q;

  // R2: cycle power changes only at a cycle boundary
  a_r2_pwr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_end |=> $stable(cyc_pwr));

  // R5: samples of other phases leave the running sum alone
  a_r5_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !cycle_end) |=> $stable(sum_q));
endmodule

// File: rtl/apa_energy_acc.sv
`timescale 1ns/1ps
module apa_energy_acc #(
  parameter int unsigned POW_W = 32,
  parameter int unsigned WIN_W = 37,
  parameter int unsigned ACC_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_stb,
  input  logic             per_stb,
  input  logic [POW_W-1:0] cyc_pwr,
  output logic [WIN_W-1:0] res_win,
  output logic [ACC_W-1:0] res_imp,
  output logic [ACC_W-1:0] res_exp
);
  logic             neg;
  logic [POW_W-1:0] mag;
  logic [ACC_W:0]   imp_sum, exp_sum;
  logic [ACC_W-1:0] imp_q, imp_nx, exp_q, exp_nx;
  logic [WIN_W-1:0] win_q, win_nx, win_add;
  logic [WIN_W-1:0] s_win_q, s_win_nx;
  logic [ACC_W-1:0] s_imp_q, s_imp_nx, s_exp_q, s_exp_nx;

  assign neg     = cyc_pwr[POW_W-1];
  assign mag     = neg ? (~cyc_pwr + 1'b1) : cyc_pwr;
  assign imp_sum = {1'b0, imp_q} + (ACC_W+1)'(mag);
  assign exp_sum = {1'b0, exp_q} + (ACC_W+1)'(mag);
  assign win_add = win_q + WIN_W'($signed(cyc_pwr));

  always_comb begin
    imp_nx   = imp_q;
    exp_nx   = exp_q;
    win_nx   = win_q;
    s_win_nx = s_win_q;
    s_imp_nx = s_imp_q;
    s_exp_nx = s_exp_q;
    if (cyc_stb) begin
      if (neg) begin
        exp_nx = exp_sum[ACC_W] ? '1 : exp_sum[ACC_W-1:0];
      end else begin
        imp_nx = imp_sum[ACC_W] ? '1 : imp_sum[ACC_W-1:0];
      end
      win_nx = win_add;
      if (per_stb) begin
        s_win_nx = win_add;
        s_imp_nx = imp_nx;
        s_exp_nx = exp_nx;
        win_nx   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imp_q   <= '0;
      exp_q   <= '0;
      win_q   <= '0;
      s_win_q <= '0;
      s_imp_q <= '0;
      s_exp_q <= '0;
    end else begin
      imp_q   <= imp_nx;
      exp_q   <= exp_nx;
      win_q   <= win_nx;
      s_win_q <= s_win_nx;
      s_imp_q <= s_imp_nx;
      s_exp_q <= s_exp_nx;
    end
  end

  assign res_win = s_win_q;
  assign res_imp = s_imp_q;
  assign res_exp = s_exp_q;

  // R7: energy never decreases, so saturation cannot wrap
  a_r7_imp_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_stb |=> (imp_q >= $past(imp_q)));
  a_r7_exp_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_stb |=> (exp_q >= $past(exp_q)));

  // R6: sign steering keeps the other register untouched
  a_r6_neg_skips_imp: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && neg) |=> (imp_q == $past(imp_q)));
  a_r6_pos_skips_exp: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && !neg) |=> (exp_q == $past(exp_q)));
endmodule

// File: rtl/apa_power_acc.sv
`timescale 1ns/1ps
module apa_power_acc
  import apa_pkg::*;
#(
  parameter int unsigned PHASES     = 3,
  parameter int unsigned SMP_W      = 16,
  parameter int unsigned CYC_LEN    = 64,
  parameter int unsigned PERIOD_CYC = 10,
  parameter int unsigned ACC_W      = 48,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned WIN_W      = 2 * SMP_W + $clog2(PERIOD_CYC) + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      smp_vld,
  input  logic [PH_W-1:0]           smp_ph,
  input  logic [SMP_W-1:0]          smp_i,
  input  logic [SMP_W-1:0]          smp_u,
  output logic                      cyc_vld,
  output logic [PHASES*2*SMP_W-1:0] cyc_pwr,
  output logic [2*SMP_W+1:0]        cyc_tot,
  output logic                      res_vld,
  output logic [PHASES*WIN_W-1:0]   res_win,
  output logic [WIN_W+1:0]          res_tot,
  output logic [PHASES*ACC_W-1:0]   res_imp,
  output logic [PHASES*ACC_W-1:0]   res_exp,
  output logic [CNT_W-1:0]          res_periods
);
  localparam int unsigned POW_W = 2 * SMP_W;
  localparam int unsigned CTOT_W = POW_W + 2;
  localparam int unsigned RTOT_W = WIN_W + 2;

  logic [1:0]       rst_sync;
  logic             rst_nq;
  logic             cycle_end, period_end;
  logic             cyc_stb_q, per_stb_q, res_vld_q;
  logic             res_vld_nx;
  logic [CNT_W-1:0] period_q, period_nx;
  logic [CTOT_W-1:0] ctot_c;
  logic [RTOT_W-1:0] rtot_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= '0;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_nq = rst_sync[1];

  apa_sample_ctr #(
    .PHASES     (PHASES),
    .CYC_LEN    (CYC_LEN),
    .PERIOD_CYC (PERIOD_CYC)
  ) u_ctr (
    .clk        (clk),
    .rst_n      (rst_nq),
    .smp_vld    (smp_vld),
    .smp_ph     (smp_ph),
    .cycle_end  (cycle_end),
    .period_end (period_end)
  );

  for (genvar k = 0; k < PHASES; k++) begin : g_phase
    apa_phase_mac #(
      .SMP_W   (SMP_W),
      .CYC_LEN (CYC_LEN),
      .PH_IDX  (k)
    ) u_mac (
      .clk       (clk),
      .rst_n     (rst_nq),
      .smp_vld   (smp_vld),
      .smp_ph    (smp_ph),
      .smp_i     (smp_i),
      .smp_u     (smp_u),
      .cycle_end (cycle_end),
      .cyc_pwr   (cyc_pwr[k*POW_W +: POW_W])
    );

    apa_energy_acc #(
      .POW_W (POW_W),
      .WIN_W (WIN_W),
      .ACC_W (ACC_W)
    ) u_energy (
      .clk     (clk),
      .rst_n   (rst_nq),
      .cyc_stb (cyc_stb_q),
      .per_stb (per_stb_q),
      .cyc_pwr (cyc_pwr[k*POW_W +: POW_W]),
      .res_win (res_win[k*WIN_W +: WIN_W]),
      .res_imp (res_imp[k*ACC_W +: ACC_W]),
      .res_exp (res_exp[k*ACC_W +: ACC_W])
    );
  end

  always_comb begin
    ctot_c = '0;
    rtot_c = '0;
    for (int k = 0; k < PHASES; k++) begin
      ctot_c = ctot_c + CTOT_W'($signed(cyc_pwr[k*POW_W +: POW_W]));
      rtot_c = rtot_c + RTOT_W'($signed(res_win[k*WIN_W +: WIN_W]));
    end
  end

  always_comb begin
    res_vld_nx = cyc_stb_q && per_stb_q;
    period_nx  = res_vld_nx ? period_q + 1'b1 : period_q;
  end

  always_ff @(posedge clk or negedge rst_nq) begin
    if (!rst_nq) begin
      cyc_stb_q <= 1'b0;
      per_stb_q <= 1'b0;
      res_vld_q <= 1'b0;
      period_q  <= '0;
    end else begin
      cyc_stb_q <= cycle_end;
      per_stb_q <= period_end;
      res_vld_q <= res_vld_nx;
      period_q  <= period_nx;
    end
  end

  assign cyc_vld     = cyc_stb_q;
  assign cyc_tot     = ctot_c;
  assign res_vld     = res_vld_q;
  assign res_tot     = rtot_c;
  assign res_periods = period_q;

  // R8: a snapshot always follows a cycle strobe by one clock
  a_r8_res_after_cycle: assert property (@(posedge clk) disable iff (!rst_nq)
    res_vld |-> $past(cyc_vld));

  // R8: the period count holds between snapshots
  a_r8_count_stable: assert property (@(posedge clk) disable iff (!rst_nq)
    !res_vld |-> $stable(res_periods));

  // R10: each snapshot advances the period count by one
  a_r10_period_step: assert property (@(posedge clk) disable iff (!rst_nq)
    res_vld |-> (res_periods == CNT_W'($past(res_periods) + 1'b1)));

  // R2: the cycle strobe is a single-clock pulse
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_nq)
    cyc_vld |=> !cyc_vld);
endmodule

// File: tb/apa_power_acc_bench.sv
`timescale 1ns/1ps
module apa_power_acc_bench;
  localparam int PHASES = 3;
  localparam int SMP_W  = 16;
  localparam int POW_W  = 32;
  localparam int WIN_W  = 37;
  localparam int ACC_W  = 48;
  localparam int SAT_W  = 32;
  localparam int CNT_W  = 32;

  // Each row: ph0 i,u; ph1 i,u; ph2 i,u; replacement i,u for phase-0 sample 63
  localparam int VEC [10][8] = '{
    '{   100,    200,   -50,   300,     0,     0,   100,    200},
    '{     1,      1,     1,     1,     1,     1,     0,      0},
    '{     0,      0,     0,     0,     0,     0,    -1,      1},
    '{-32768, -32768,     0,     0,     0,     0,-32768, -32768},
    '{ 32767, -32768,     5,     5,    -3,     7, 32767, -32768},
    '{  1000,  -1000,  2000,  2000,     7,     7,     0,      0},
    '{  -123,    456,   789,  -321,   555,   555,  -123,    456},
    '{     3,     -1,    -2,    -2, 12345,   -17,     1,     -1},
    '{ 20000,  20000,-20000, 20000,   -40,   -40,     0,      0},
    '{    -7,      9,   100,  -100, 30000,  30000,     5,      5}
  };
  localparam int SATV [8] = '{-32768, -32768, -32768, 32767, 0, 0, -32768, -32768};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                      rst_n;
  logic                      smp_vld;
  logic [1:0]                smp_ph;
  logic [SMP_W-1:0]          smp_i, smp_u;
  logic                      cyc_vld, cyc_vld_s;
  logic [PHASES*POW_W-1:0]   cyc_pwr, cyc_pwr_s;
  logic [POW_W+1:0]          cyc_tot, cyc_tot_s;
  logic                      res_vld, res_vld_s;
  logic [PHASES*WIN_W-1:0]   res_win, res_win_s;
  logic [WIN_W+1:0]          res_tot, res_tot_s;
  logic [PHASES*ACC_W-1:0]   res_imp, res_exp;
  logic [PHASES*SAT_W-1:0]   res_imp_s, res_exp_s;
  logic [CNT_W-1:0]          res_periods, res_periods_s;

  apa_power_acc u_apa_power_acc (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_ph(smp_ph),
    .smp_i(smp_i), .smp_u(smp_u), .cyc_vld(cyc_vld), .cyc_pwr(cyc_pwr),
    .cyc_tot(cyc_tot), .res_vld(res_vld), .res_win(res_win), .res_tot(res_tot),
    .res_imp(res_imp), .res_exp(res_exp), .res_periods(res_periods)
  );

  apa_power_acc #(.ACC_W(SAT_W)) u_apa_power_acc_sat (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_ph(smp_ph),
    .smp_i(smp_i), .smp_u(smp_u), .cyc_vld(cyc_vld_s), .cyc_pwr(cyc_pwr_s),
    .cyc_tot(cyc_tot_s), .res_vld(res_vld_s), .res_win(res_win_s), .res_tot(res_tot_s),
    .res_imp(res_imp_s), .res_exp(res_exp_s), .res_periods(res_periods_s)
  );

  int errors = 0;
  int checks = 0;
  longint m_imp [PHASES];
  longint m_exp [PHASES];
  longint m_win [PHASES];
  longint m_per;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint clampw(input longint v, input int w);
    longint lim;
    lim = (longint'(1) << w) - 1;
    return (v > lim) ? lim : v;
  endfunction

  task automatic model_clear();
    for (int p = 0; p < PHASES; p++) begin
      m_imp[p] = 0;
      m_exp[p] = 0;
      m_win[p] = 0;
    end
    m_per = 0;
  endtask

  task automatic drive(input int ph, input int i, input int u, input logic vld);
    @(negedge clk);
    smp_vld = vld;
    smp_ph  = 2'(ph);
    smp_i   = 16'(i);
    smp_u   = 16'(u);
  endtask

  task automatic check_reset_state(input string tag);
    chk({tag, " R1 cyc_vld"}, longint'(cyc_vld), 0);
    chk({tag, " R1 res_vld"}, longint'(res_vld), 0);
    chk({tag, " R1 res_periods"}, longint'(res_periods), 0);
    chk({tag, " R1 cyc_pwr zero"}, longint'(|cyc_pwr), 0);
    chk({tag, " R1 energy zero"}, longint'(|res_imp | |res_exp), 0);
    chk({tag, " R1 res_tot"}, longint'(|res_tot), 0);
  endtask

  task automatic check_period();
    longint tot;
    tot = 0;
    chk("R8 res_vld pulse", longint'(res_vld), 1);
    chk("R10 res_periods", longint'(res_periods), m_per);
    for (int p = 0; p < PHASES; p++) begin
      chk($sformatf("R9 res_win ph%0d", p), $signed(res_win[p*WIN_W +: WIN_W]), m_win[p]);
      chk($sformatf("R6 res_imp ph%0d", p), longint'(res_imp[p*ACC_W +: ACC_W]), clampw(m_imp[p], ACC_W));
      chk($sformatf("R6 res_exp ph%0d", p), longint'(res_exp[p*ACC_W +: ACC_W]), clampw(m_exp[p], ACC_W));
      chk($sformatf("R7 sat imp ph%0d", p), longint'(res_imp_s[p*SAT_W +: SAT_W]), clampw(m_imp[p], SAT_W));
      chk($sformatf("R7 sat exp ph%0d", p), longint'(res_exp_s[p*SAT_W +: SAT_W]), clampw(m_exp[p], SAT_W));
      tot += m_win[p];
      m_win[p] = 0;
    end
    chk("R9 res_tot", $signed(res_tot), tot);
  endtask

  task automatic run_cycle(input int v [8], input bit last);
    longint e [PHASES];
    longint tot;
    tot = 0;
    for (int p = 0; p < PHASES; p++) begin
      e[p] = (64 * longint'(v[2*p]) * longint'(v[2*p+1])) >>> 6;
    end
    e[0] = (63 * longint'(v[0]) * longint'(v[1]) + longint'(v[6]) * longint'(v[7])) >>> 6;
    for (int s = 0; s < 64; s++) begin
      for (int p = 0; p < PHASES; p++) begin
        if (s == 63 && p == 0) drive(p, v[6], v[7], 1'b1);
        else                   drive(p, v[2*p], v[2*p+1], 1'b1);
      end
      if (s != 63) begin
        drive(3, -32768, -32768, 1'b1);   // R5: invalid phase index
        drive(0, 32767, 32767, 1'b0);     // R5: strobe low
      end
    end
    @(negedge clk);
    smp_vld = 1'b0;
    chk("R2 cyc_vld high", longint'(cyc_vld), 1);
    for (int p = 0; p < PHASES; p++) begin
      chk($sformatf("R2 cyc_pwr ph%0d", p), $signed(cyc_pwr[p*POW_W +: POW_W]), e[p]);
      tot += e[p];
      m_win[p] += e[p];
      if (e[p] >= 0) m_imp[p] += e[p];
      else           m_exp[p] -= e[p];
    end
    chk("R4 cyc_tot", $signed(cyc_tot), tot);
    @(negedge clk);
    chk("R2 cyc_vld single", longint'(cyc_vld), 0);
    if (last) begin
      m_per++;
      check_period();
    end else begin
      chk("R8 res_vld low", longint'(res_vld), 0);
      chk("R8 res_periods held", longint'(res_periods), m_per);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    smp_vld = 1'b0;
    smp_ph  = '0;
    smp_i   = '0;
    smp_u   = '0;
    model_clear();
    repeat (3) @(negedge clk);
    check_reset_state("start");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state("released");

    // Table walk: one full period of mixed patterns, R2 R3 R4 R5 R6 R9 R10
    for (int k = 0; k < 10; k++) begin
      run_cycle(VEC[k], k == 9);
    end
    chk("R3 full scale cycle", longint'(m_imp[0] > 0), 1);

    // Reset in mid-life clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state("mid");
    rst_n = 1'b1;
    model_clear();
    repeat (3) @(negedge clk);

    // Saturation period: full-scale import on phase 0, export on phase 1 (R7)
    for (int k = 0; k < 10; k++) begin
      run_cycle(SATV, k == 9);
    end
    chk("R7 sat imp at limit", longint'(res_imp_s[0 +: SAT_W]), (longint'(1) << SAT_W) - 1);
    chk("R7 sat exp at limit", longint'(res_exp_s[SAT_W +: SAT_W]), (longint'(1) << SAT_W) - 1);

    // Second period from the same table to see the count advance (R10)
    for (int k = 0; k < 10; k++) begin
      run_cycle(VEC[k], k == 9);
    end
    chk("R10 two periods", longint'(res_periods), 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule